// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central bookkeeping unit for a pipeline that lets instructions finish out of order. Decoded instructions come in one per cycle through a valid/ready issue port. Each carries an operation class, a destination register and two source registers. The block tracks five execution units: Integer, Mult1, Mult2, Add and Divide. For each unit it keeps the destination, the sources, the units that will produce those sources, and whether each source can be read yet. A second table, indexed by register, records which unit will write that register.

The block resolves each hazard at its own stage:

- **Issue:** stalls on a busy unit (structural hazard) or on a destination that already has a pending writer (write-after-write).
- **Operand read:** a unit is granted its read only when both sources are free of pending producers (read-after-write).
- **Writeback:** a finished unit is granted the write port only when no other unit still has to read the old value of its destination (write-after-read).

The execution datapaths sit outside the block. They see read grants and return one-cycle completion pulses. The register file sees a write enable and a write address.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves every unit idle, every register without a pending writer and every grant low. After reset any instruction is accepted, since its unit is free and its destination is unclaimed.
- R2: Instruction classes are encoded as 0 Integer, 1 multiply, 2 Add, 3 Divide. An instruction is held (iss_ready low) while its class's unit is busy. A multiply goes to Mult1 when Mult1 is idle, otherwise to Mult2, and is held only when both are busy.
- R3: An instruction is held while the register-owner table shows a pending writer for its destination register.
- R4: Issue is in order, at most one per cycle: an instruction is accepted at the edge where iss_valid and iss_ready are both high, and a held instruction blocks all later ones. Stage codes are 0 idle, 1 issued, 2 operands read, 3 execution complete. Unit u reports its stage on fu_stage[2u+1:2u], with unit indices 0 Integer, 1 Mult1, 2 Mult2, 3 Add, 4 Divide. The accepting unit shows stage 1 in the next cycle.
- R5: rd_grant[u] is high for exactly one cycle, in a cycle where unit u is in stage 1 and neither source waits on a producing unit. The unit shows stage 2 in the next cycle.
- R6: exe_done[u] moves unit u from stage 2 to stage 3 at the next edge. A completion pulse to a unit in any other stage is ignored.
- R7: A unit in stage 3 is refused writeback while another unit has, as an unread source, the register this unit will write.
- R8: Among the units eligible for writeback, the one with the lowest index is granted. At most one grant is given per cycle.
- R9: In the writeback cycle, rf_we is high and rf_waddr carries the granted unit's destination. From the next cycle the unit is idle and that register has no pending writer.
- R10: A source waiting on a unit becomes readable in the cycle after that unit's writeback. This includes an instruction that issues in the same cycle as the writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Decoded instruction present |
| iss_ready | output | 1 | Instruction accepted this cycle when valid |
| iss_cls | input | 2 | Operation class (0 Integer, 1 multiply, 2 Add, 3 Divide) |
| iss_dst | input | log2(NUM_REGS) | Destination register |
| iss_src1 | input | log2(NUM_REGS) | First source register |
| iss_src2 | input | log2(NUM_REGS) | Second source register |
| rd_grant | output | 5 | Per-unit operand read grant, starts execution |
| exe_done | input | 5 | Per-unit completion pulse |
| wb_grant | output | 5 | Per-unit writeback grant |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | log2(NUM_REGS) | Register file write address |
| fu_stage | output | 10 | Two-bit stage code per unit |

## Verification
The bench builds the block with its default of 32 registers. It models the execution units with latencies of 3 cycles for Integer, 10 for each multiplier, 2 for Add and 40 for Divide.

The equal Integer and Add completion times let two units become eligible for writeback in the same cycle, which exercises the priority rule. The long divide keeps write-after-read stalls open for dozens of cycles.

A pseudo-random stream confined to eight registers packs read-after-write, write-after-write and write-after-read conflicts closely together. That density makes a writeback that coincides with the issue of a dependent instruction likely to occur.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int NUM_FU = 5;
   localparam int CODE_W = 3;

   localparam int FU_INT  = 0;
   localparam int FU_MUL1 = 1;
   localparam int FU_MUL2 = 2;
   localparam int FU_ADD  = 3;
   localparam int FU_DIV  = 4;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_MUL = 2'd1,
      CLS_ADD = 2'd2,
      CLS_DIV = 2'd3
   } op_cls_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUED = 2'd1,
      ST_READ   = 2'd2,
      ST_DONE   = 2'd3
   } fu_stage_t;
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
   import sb_pkg::*;
(
   input  logic [1:0]        iss_cls,
   input  logic [NUM_FU-1:0] fu_busy,
   output logic [NUM_FU-1:0] pick_oh,
   output logic              pick_ok
);
   always_comb begin
      pick_oh = '0;
      case (op_cls_t'(iss_cls))
         CLS_INT: pick_oh[FU_INT] = !fu_busy[FU_INT];
         CLS_MUL: begin
            if (!fu_busy[FU_MUL1])      pick_oh[FU_MUL1] = 1'b1;
            else if (!fu_busy[FU_MUL2]) pick_oh[FU_MUL2] = 1'b1;
         end
         CLS_ADD: pick_oh[FU_ADD] = !fu_busy[FU_ADD];
         CLS_DIV: pick_oh[FU_DIV] = !fu_busy[FU_DIV];
      endcase
   end

   assign pick_ok = |pick_oh;
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
   import sb_pkg::*;
#(
   parameter int RIDX   = 5,
   parameter int CODE_W_P = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                iss_en,
   input  logic [RIDX-1:0]     iss_fi,
   input  logic [RIDX-1:0]     iss_fj,
   input  logic [RIDX-1:0]     iss_fk,
   input  logic [CODE_W_P-1:0] iss_qj,
   input  logic [CODE_W_P-1:0] iss_qk,
   input  logic [CODE_W_P-1:0] wb_code,
   input  logic                wb_me,
   input  logic                done,
   output logic                rd_go,
   output logic [1:0]          stage,
   output logic [RIDX-1:0]     fi,
   output logic [RIDX-1:0]     fj,
   output logic [RIDX-1:0]     fk,
   output logic                rj,
   output logic                rk
);
   logic [CODE_W_P-1:0] qj, qk, qj_new, qk_new;

   // a producer writing back in the issue cycle no longer counts as pending
   assign qj_new = (iss_qj == wb_code) ? '0 : iss_qj;
   assign qk_new = (iss_qk == wb_code) ? '0 : iss_qk;
   assign rd_go  = (stage == ST_ISSUED) && rj && rk;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage <= ST_IDLE;
         fi <= '0;
         fj <= '0;
         fk <= '0;
         qj <= '0;
         qk <= '0;
         rj <= 1'b0;
         rk <= 1'b0;
      end else if (iss_en) begin
         stage <= ST_ISSUED;
         fi <= iss_fi;
         fj <= iss_fj;
         fk <= iss_fk;
         qj <= qj_new;
         qk <= qk_new;
         rj <= (qj_new == '0);
         rk <= (qk_new == '0);
      end else if (wb_me) begin
         stage <= ST_IDLE;
         qj <= '0;
         qk <= '0;
         rj <= 1'b0;
         rk <= 1'b0;
      end else begin
         if (rd_go) begin
            stage <= ST_READ;
            rj <= 1'b0;
            rk <= 1'b0;
         end else if (stage == ST_READ && done) begin
            stage <= ST_DONE;
         end
         if (wb_code != '0 && qj == wb_code) begin
            qj <= '0;
            rj <= 1'b1;
         end
         if (wb_code != '0 && qk == wb_code) begin
            qk <= '0;
            rk <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
   parameter int NFU  = 5,
   parameter int RIDX = 5
) (
   input  logic [NFU-1:0]           done_st,
   input  logic [NFU-1:0]           rj,
   input  logic [NFU-1:0]           rk,
   input  logic [NFU-1:0][RIDX-1:0] fi,
   input  logic [NFU-1:0][RIDX-1:0] fj,
   input  logic [NFU-1:0][RIDX-1:0] fk,
   output logic [NFU-1:0]           grant
);
   logic [NFU-1:0] elig;

   // write-after-read: another unit still owes a read of our destination
   always_comb begin
      elig = done_st;
      for (int u = 0; u < NFU; u++) begin
         for (int v = 0; v < NFU; v++) begin
            if (v != u && ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
               elig[u] = 1'b0;
         end
      end
   end

   always_comb begin
      grant = '0;
      for (int u = NFU - 1; u >= 0; u--) begin
         if (elig[u]) begin
            grant    = '0;
            grant[u] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
   import sb_pkg::*;
#(
   parameter int  NUM_REGS = 32,
   localparam int RIDX     = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                iss_valid,
   output logic                iss_ready,
   input  logic [1:0]          iss_cls,
   input  logic [RIDX-1:0]     iss_dst,
   input  logic [RIDX-1:0]     iss_src1,
   input  logic [RIDX-1:0]     iss_src2,
   output logic [NUM_FU-1:0]   rd_grant,
   input  logic [NUM_FU-1:0]   exe_done,
   output logic [NUM_FU-1:0]   wb_grant,
   output logic                rf_we,
   output logic [RIDX-1:0]     rf_waddr,
   output logic [2*NUM_FU-1:0] fu_stage
);
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if ((1 << CODE_W) <= NUM_FU) begin : g_bad_code
      $error("CODE_W too narrow for the unit count");
   end

   logic [CODE_W-1:0]           reg_owner [NUM_REGS];
   logic [NUM_FU-1:0]           fu_busy, fu_done_st, fu_rj, fu_rk, pick_oh;
   logic [NUM_FU-1:0][RIDX-1:0] fu_fi, fu_fj, fu_fk;
   logic [CODE_W-1:0]           wb_code, pick_code;
   logic                        pick_ok, iss_fire;

   sb_issue_sel u_sel (
      .iss_cls (iss_cls),
      .fu_busy (fu_busy),
      .pick_oh (pick_oh),
      .pick_ok (pick_ok)
   );

   assign iss_ready = pick_ok && (reg_owner[iss_dst] == '0);
   assign iss_fire  = iss_valid && iss_ready;

   sb_wb_arb #(.NFU(NUM_FU), .RIDX(RIDX)) u_arb (
      .done_st (fu_done_st),
      .rj      (fu_rj),
      .rk      (fu_rk),
      .fi      (fu_fi),
      .fj      (fu_fj),
      .fk      (fu_fk),
      .grant   (wb_grant)
   );

   always_comb begin
      wb_code   = '0;
      pick_code = '0;
      rf_waddr  = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         if (wb_grant[u]) begin
            wb_code  = CODE_W'(u + 1);
            rf_waddr = fu_fi[u];
         end
         if (pick_oh[u]) pick_code = CODE_W'(u + 1);
      end
   end

   assign rf_we = |wb_grant;

   for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
      logic [1:0] st;
      sb_fu_entry #(.RIDX(RIDX), .CODE_W_P(CODE_W)) u_ent (
         .clk     (clk),
         .rst     (rst),
         .iss_en  (iss_fire && pick_oh[u]),
         .iss_fi  (iss_dst),
         .iss_fj  (iss_src1),
         .iss_fk  (iss_src2),
         .iss_qj  (reg_owner[iss_src1]),
         .iss_qk  (reg_owner[iss_src2]),
         .wb_code (wb_code),
         .wb_me   (wb_grant[u]),
         .done    (exe_done[u]),
         .rd_go   (rd_grant[u]),
         .stage   (st),
         .fi      (fu_fi[u]),
         .fj      (fu_fj[u]),
         .fk      (fu_fk[u]),
         .rj      (fu_rj[u]),
         .rk      (fu_rk[u])
      );
      assign fu_stage[2*u +: 2] = st;
      assign fu_busy[u]         = (st != ST_IDLE);
      assign fu_done_st[u]      = (st == ST_DONE);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NUM_REGS; r++) reg_owner[r] <= '0;
      end else begin
         if (rf_we)    reg_owner[rf_waddr] <= '0;
         if (iss_fire) reg_owner[iss_dst]  <= pick_code;
      end
   end
endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk
   import sb_pkg::*;
#(
   parameter int RIDX = 5
) (
   input logic                clk,
   input logic                rst,
   input logic                iss_valid,
   input logic                iss_ready,
   input logic [1:0]          iss_cls,
   input logic [RIDX-1:0]     iss_dst,
   input logic [NUM_FU-1:0]   rd_grant,
   input logic [NUM_FU-1:0]   exe_done,
   input logic [NUM_FU-1:0]   wb_grant,
   input logic [2*NUM_FU-1:0] fu_stage
);
   p_wb_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wb_grant));

   p_waw_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_ready) |=> !(iss_ready && iss_dst == $past(iss_dst)));

   p_div_issue_r4: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_ready && iss_cls == 2'd3) |=> fu_stage[2*FU_DIV +: 2] == 2'd1);

   for (genvar u = 0; u < NUM_FU; u++) begin : g_u
      p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
         rd_grant[u] |=> (!rd_grant[u] && fu_stage[2*u +: 2] == 2'd2));

      p_done_step_r6: assert property (@(posedge clk) disable iff (rst)
         (fu_stage[2*u +: 2] == 2'd2 && exe_done[u]) |=> fu_stage[2*u +: 2] == 2'd3);

      p_wb_from_done_r9: assert property (@(posedge clk) disable iff (rst)
         wb_grant[u] |-> fu_stage[2*u +: 2] == 2'd3);

      p_wb_frees_r9: assert property (@(posedge clk) disable iff (rst)
         wb_grant[u] |=> fu_stage[2*u +: 2] == 2'd0);
   end
endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(.RIDX(RIDX)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .iss_cls   (iss_cls),
   .iss_dst   (iss_dst),
   .rd_grant  (rd_grant),
   .exe_done  (exe_done),
   .wb_grant  (wb_grant),
   .fu_stage  (fu_stage)
);

// File: tb/test_sb_hazard_ctrl.sv
module test_sb_hazard_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       iss_valid = 1'b0;
   logic       iss_ready;
   logic [1:0] iss_cls = '0;
   logic [4:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
   logic [4:0] rd_grant, wb_grant;
   logic [4:0] exe_done = '0;
   logic       rf_we;
   logic [4:0] rf_waddr;
   logic [9:0] fu_stage;

   always #4 clk = ~clk;

   sb_hazard_ctrl i_sb_hazard_ctrl (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_cls(iss_cls), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .rd_grant(rd_grant), .exe_done(exe_done), .wb_grant(wb_grant),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .fu_stage(fu_stage)
   );

   typedef struct { int cls; int dst; int s1; int s2; } ins_t;
   ins_t prog[$];

   int m_st[5], m_fi[5], m_fj[5], m_fk[5], m_qj[5], m_qk[5], cnt[5];
   bit m_rj[5], m_rk[5];
   int m_own[32];
   int lat[5] = '{3, 10, 10, 2, 40};
   logic [4:0] spur = '0;
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit timeout = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic add(input int c, input int d, input int a, input int b);
      ins_t t;
      t.cls = c; t.dst = d; t.s1 = a; t.s2 = b;
      prog.push_back(t);
   endtask

   task automatic step();
      logic [4:0] dn, erd, ewb;
      logic [9:0] est;
      int pick, wbu, ecode;
      bit rdy;
      dn = spur;
      spur = '0;
      for (int u = 0; u < 5; u++)
         if (cnt[u] > 0) begin
            cnt[u]--;
            if (cnt[u] == 0) dn[u] = 1'b1;
         end
      exe_done = dn;
      if (prog.size() > 0) begin
         iss_valid = 1'b1;
         iss_cls = prog[0].cls[1:0];
         iss_dst = prog[0].dst[4:0];
         iss_src1 = prog[0].s1[4:0];
         iss_src2 = prog[0].s2[4:0];
      end else begin
         iss_valid = 1'b0; iss_cls = '0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
      end
      #1;
      pick = -1;
      case (iss_cls)
         2'd0: begin if (m_st[0] == 0) pick = 0; end
         2'd1: begin if (m_st[1] == 0) pick = 1; else if (m_st[2] == 0) pick = 2; end
         2'd2: begin if (m_st[3] == 0) pick = 3; end
         default: begin if (m_st[4] == 0) pick = 4; end
      endcase
      rdy = (pick >= 0) && (m_own[iss_dst] == 0);
      wbu = -1;
      for (int u = 0; u < 5; u++) begin
         bit ok;
         erd[u] = (m_st[u] == 1) && m_rj[u] && m_rk[u];
         est[2*u +: 2] = m_st[u][1:0];
         ok = (m_st[u] == 3);
         for (int v = 0; v < 5; v++)
            if (v != u && ((m_rj[v] && m_fj[v] == m_fi[u]) || (m_rk[v] && m_fk[v] == m_fi[u])))
               ok = 0;
         if (ok && wbu < 0) wbu = u;
      end
      ewb = (wbu >= 0) ? (5'b1 << wbu) : 5'b0;
      chk(iss_ready === rdy, "R2 R3 issue ready", int'(iss_ready), int'(rdy));
      chk(rd_grant === erd, "R5 R10 operand read grant", int'(rd_grant), int'(erd));
      chk(wb_grant === ewb, "R7 R8 writeback grant", int'(wb_grant), int'(ewb));
      chk(rf_we === (wbu >= 0) && (wbu < 0 || int'(rf_waddr) == m_fi[wbu]),
          "R9 register write", int'({rf_we, rf_waddr}),
          (wbu >= 0) ? (32 + m_fi[wbu]) : 0);
      chk(fu_stage === est, "R4 R6 unit stage", int'(fu_stage), int'(est));
      ecode = wbu + 1;
      for (int u = 0; u < 5; u++) begin
         if (u == wbu) begin
            m_st[u] = 0; m_rj[u] = 0; m_rk[u] = 0; m_qj[u] = 0; m_qk[u] = 0;
         end else begin
            if (erd[u]) begin
               m_st[u] = 2; m_rj[u] = 0; m_rk[u] = 0; cnt[u] = lat[u];
            end else if (m_st[u] == 2 && dn[u]) m_st[u] = 3;
            if (ecode > 0 && m_qj[u] == ecode) begin m_qj[u] = 0; m_rj[u] = 1; end
            if (ecode > 0 && m_qk[u] == ecode) begin m_qk[u] = 0; m_rk[u] = 1; end
         end
      end
      if (wbu >= 0) m_own[m_fi[wbu]] = 0;
      if (iss_valid && rdy) begin
         m_st[pick] = 1;
         m_fi[pick] = iss_dst; m_fj[pick] = iss_src1; m_fk[pick] = iss_src2;
         m_qj[pick] = m_own[iss_src1];
         m_qk[pick] = m_own[iss_src2];
         if (m_qj[pick] == ecode) m_qj[pick] = 0;
         if (m_qk[pick] == ecode) m_qk[pick] = 0;
         m_rj[pick] = (m_qj[pick] == 0);
         m_rk[pick] = (m_qk[pick] == 0);
         m_own[iss_dst] = pick + 1;
         void'(prog.pop_front());
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic run();
      bit idle;
      idle = 0;
      while (!idle && !timeout) begin
         step();
         idle = (prog.size() == 0);
         for (int u = 0; u < 5; u++) if (m_st[u] != 0 || cnt[u] != 0) idle = 0;
         if (cyc > 150000) timeout = 1;
      end
   endtask

   initial begin
      int s;
      for (int u = 0; u < 5; u++) begin
         m_st[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
         m_qj[u] = 0; m_qk[u] = 0; m_rj[u] = 0; m_rk[u] = 0; cnt[u] = 0;
      end
      for (int r = 0; r < 32; r++) m_own[r] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, including an instruction offered during reset
      iss_valid = 1'b1; iss_cls = 2'd3; iss_dst = 5'd9;
      @(negedge clk);
      chk(fu_stage === '0, "R1 stages idle in reset", int'(fu_stage), 0);
      rst = 1'b0;
      #1;
      chk(iss_ready === 1'b1, "R1 ready after reset", int'(iss_ready), 1);
      chk(rd_grant === '0 && wb_grant === '0 && rf_we === 1'b0, "R1 grants low",
          int'({rf_we, wb_grant, rd_grant}), 0);
      iss_valid = 1'b0;
      @(negedge clk);

      // dependency chain with RAW, WAR and structural stalls
      add(0, 6, 31, 31); add(0, 2, 31, 31); add(1, 0, 2, 4);
      add(2, 8, 6, 2);   add(3, 10, 0, 6);  add(2, 6, 8, 2);
      run();

      // R6: completion pulses to idle units are ignored
      spur = 5'b11111;
      step();
      chk(fu_stage === '0, "R6 stray completion ignored", int'(fu_stage), 0);

      // R2: multipliers fill in order, third waits; R3: WAW on F1
      add(1, 1, 3, 4); add(1, 5, 3, 4); add(1, 7, 3, 4); add(2, 1, 5, 7);
      run();

      // R8: Integer and Add complete together
      add(0, 12, 30, 30); add(2, 13, 14, 15);
      run();

      // R10 and mixed hazards: pseudo-random stream over eight registers
      s = 32'h1d3a;
      for (int i = 0; i < 80; i++) begin
         s = (s * 1103515245 + 12345) & 32'h7fffffff;
         add((s >> 4) % 4, (s >> 8) % 8, (s >> 12) % 8, (s >> 16) % 8);
      end
      run();

      if (timeout) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R4: actual %0d expected %0d", cyc, 150000);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule